// File: doc/BRIEF.md
# Configurable Synchronous Serial Transmitter

This block turns parallel words into a serial bit stream with a matching frame-sync marker. Words enter through a one-entry holding register with a valid/ready handshake. A framing engine moves each word out one bit per bit-clock period on `ser_dout` and marks word boundaries on `ser_fs`. The bit clock either comes from an internal divider of the system clock or is taken from an external pin through a synchronizer. In both cases it is brought out on `ser_sclk`, so the receiver can sample on the opposite edge.

Static control inputs select the following: the bit order; the word length (field value plus one); whether the outputs change on the rising or the falling bit-clock edge; the frame-sync polarity; whether the marker comes with the first bit or one bit ahead of it; and whether frames start only when a word is waiting or start every frame period regardless. In the free-running case an empty holding register makes the engine resend the previous word and raises a sticky underflow flag. Software clears that flag with a one-cycle pulse. The controls are meant to be changed only while the transmitter is disabled.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset `ser_dout` is 0, `ser_fs` is at its inactive level, `s_ready` and `st_hold_empty` are 1 and `st_underflow` is 0.
- R2: While `cfg_enable` is 0, `ser_dout` stays 0, `ser_fs` stays at its inactive level, and a word in the holding register is not consumed (`s_ready` stays 0).
- R3: With `cfg_int_clk`=1, `ser_sclk` changes level every `cfg_div`+1 system clocks, giving a bit period of 2×(`cfg_div`+1) clocks.
- R4: With `cfg_int_clk`=0, `ser_sclk` is `ext_sclk` delayed through a three-flop synchronizer chain, keeping its half period, and the data is launched on its edges.
- R5: `cfg_lsb_first`=1 sends bit 0 of the word first. `cfg_lsb_first`=0 sends the most significant bit of the programmed length first.
- R6: A word carries `cfg_len`+1 bits. Field values 0 and 1 act as 2 (3 bits), and 31 gives 32 bits.
- R7: With `cfg_fall_edge`=1, `ser_dout` and `ser_fs` change only at falling transitions of `ser_sclk`. With 0, they change only at rising transitions. In both cases they are stable across the opposite transition.
- R8: `cfg_fs_low`=0 makes frame sync active-high and `cfg_fs_low`=1 makes it active-low. The idle level is the inactive one.
- R9: Frame sync is active for exactly one bit slot per word. With `cfg_fs_early`=0 that slot is the first data bit. With `cfg_fs_early`=1 it is the slot just before the first data bit, which is the last bit of the previous word when frames are back to back.
- R10: With `cfg_fs_free`=0 a frame starts only when a word is held. Queued words follow back to back, and once the data runs out no further frame sync appears and `st_underflow` stays 0.
- R11: With `cfg_fs_free`=1 a frame starts every word period. It sends the held word if there is one, and otherwise sends the previously sent word again.
- R12: `s_ready` and `st_hold_empty` are 1 exactly when the holding register is empty. A word is taken on `s_valid`&&`s_ready`, and `s_ready` is 0 from the next cycle until the engine takes that word.
- R13: `st_underflow` is set when a frame starts with an empty holding register, stays set, and is cleared by a one-cycle `uf_clear` pulse when no underflow occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Transmitter enable |
| cfg_int_clk | input | 1 | 1: internal divided bit clock, 0: external bit clock |
| cfg_div | input | 16 | Internal divider value |
| cfg_len | input | 5 | Bits per word minus one |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_fall_edge | input | 1 | 1: outputs change on falling bit-clock edge |
| cfg_fs_low | input | 1 | Frame-sync active-low select |
| cfg_fs_early | input | 1 | Frame sync one bit ahead of the first bit |
| cfg_fs_free | input | 1 | Free-running (data-independent) framing |
| ext_sclk | input | 1 | External bit clock |
| s_valid | input | 1 | Word offered |
| s_data | input | 32 | Offered word |
| s_ready | output | 1 | Holding register can accept |
| uf_clear | input | 1 | Clear the underflow flag |
| ser_sclk | output | 1 | Bit clock in use |
| ser_dout | output | 1 | Serial data |
| ser_fs | output | 1 | Frame sync |
| st_hold_empty | output | 1 | Holding register empty |
| st_underflow | output | 1 | Sticky underflow |

## Verification
Internally clocked, `ser_dout` and `ser_fs` change at the same clock edge as the launch transition of `ser_sclk`. Externally clocked, `ser_sclk` lags `ext_sclk` by three clocks and the data stays aligned to it. `s_ready` drops one clock after an accepted handshake. The underflow flag rises one clock after the frame start that found the register empty, and it falls one clock after `uf_clear`. The bench samples every output at the falling system-clock edge. Its receiver model recovers bits only at the capture transitions of `ser_sclk`, half a bit after launch. It also counts any data or frame-sync change that does not fall on a launch transition. Flag and handshake values are checked at the falling edge that follows the clock edge due to update them.

// File: rtl/sstx_pkg.sv
// Shared types and constants for the serial transmitter.
package sstx_pkg;

    // Smallest legal length field value (bits per word minus one).
    localparam int MIN_WORD_LEN = 2;

    // Framing options the engine needs; static while enabled.
    typedef struct packed {
        logic lsb_first;
        logic early;
        logic free_run;
    } frame_cfg_t;

endpackage

// File: rtl/sstx_bitclk.sv
// Bit-clock source: internal divider or synchronized external clock.
// Produces the bit-clock level and a one-cycle tick on the launch edge.
// Assumes the external clock half period spans at least three clk cycles.
module sstx_bitclk #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             use_int,
    input  logic             launch_fall,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             sclk,
    output logic             tick
);
    localparam int HIST = SYNC_STAGES;

    logic [DIV_W-1:0]     cnt_q;
    logic                 bclk_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 div_hit;
    logic                 int_edge;
    logic                 ext_edge;
    logic                 pre_level;

    assign div_hit = (cnt_q >= div);

    // Divider: toggle the internal bit clock every div+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !use_int) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (div_hit) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

    // Synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
        end
    end

    // Edge selection: tick when the chosen clock leaves the launch level.
    always_comb begin
        int_edge  = run && use_int && div_hit;
        ext_edge  = run && !use_int && (sync_q[HIST-1] != sync_q[HIST]);
        pre_level = use_int ? bclk_q : sync_q[HIST];
        tick      = (int_edge || ext_edge) && (pre_level == launch_fall);
        sclk      = pre_level;
    end

    // R3: divider count never passes the programmed limit while it is stable.
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && use_int && $stable(div) && cnt_q <= div) |=> (cnt_q <= div));

endmodule

// File: rtl/sstx_hold.sv
// One-entry holding register between the handshake and the engine.
// Assumes the engine only takes when the register is full.
module sstx_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    // Storage: load on accepted write, empty on engine take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            word <= wr_data;
        end
    end

    // R12: a held word stays put until taken.
    a_r12_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(word)));

    // R12: the engine never takes from an empty register.
    a_r12_take_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

endmodule

// File: rtl/sstx_engine.sv
// Framing engine: one output slot per launch tick. Decides frame starts,
// places frame sync (late or early), sends bits in the chosen order and
// tracks underflow. Assumes configuration is static while run is high.
module sstx_engine
    import sstx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [LEN_W-1:0]  len_cfg,
    input  frame_cfg_t        fcfg,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_word,
    input  logic              uf_clear,
    output logic              take,
    output logic              dout,
    output logic              fs_act,
    output logic              underflow
);
    localparam int               IDX_W     = $clog2(DATA_W);
    localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_WORD_LEN);

    logic              busy_q, armed_q, dout_q, fs_q, uf_q;
    logic [LEN_W-1:0]  remain_q, nxt_len_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] word_q, nxt_q, last_q;

    logic [LEN_W-1:0]  eff_len, first_len;
    logic              cont, decide, avail, start, begin_word;
    logic [DATA_W-1:0] pick_word, first_word;
    logic [IDX_W-1:0]  first_idx, step_idx;

    // Slot decision: continue the word, begin a word, or idle.
    always_comb begin
        eff_len    = (len_cfg < LEN_FLOOR) ? LEN_FLOOR : len_cfg;
        cont       = busy_q && (remain_q != '0);
        avail      = hold_full || fcfg.free_run;
        pick_word  = hold_full ? hold_word : last_q;
        if (fcfg.early) begin
            decide = !armed_q && (!cont || remain_q == LEN_W'(1));
        end else begin
            decide = !cont;
        end
        start      = run && tick && decide && avail;
        begin_word = fcfg.early ? armed_q : start;
        first_word = fcfg.early ? nxt_q : pick_word;
        first_len  = fcfg.early ? nxt_len_q : eff_len;
        first_idx  = fcfg.lsb_first ? '0 : IDX_W'(first_len);
        step_idx   = fcfg.lsb_first ? idx_q + IDX_W'(1) : idx_q - IDX_W'(1);
    end

    assign take      = start && hold_full;
    assign dout      = dout_q;
    assign fs_act    = fs_q;
    assign underflow = uf_q;

    // Slot sequencer: drive data and frame sync once per launch tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy_q   <= 1'b0;
            armed_q  <= 1'b0;
            remain_q <= '0;
            idx_q    <= '0;
            dout_q   <= 1'b0;
            fs_q     <= 1'b0;
        end else if (tick) begin
            fs_q    <= start;
            armed_q <= fcfg.early && start;
            if (begin_word) begin
                idx_q    <= first_idx;
                dout_q   <= first_word[first_idx];
                remain_q <= first_len;
                busy_q   <= 1'b1;
            end else if (cont) begin
                idx_q    <= step_idx;
                dout_q   <= word_q[step_idx];
                remain_q <= remain_q - LEN_W'(1);
            end else begin
                busy_q   <= 1'b0;
                dout_q   <= 1'b0;
            end
        end
    end

    // Word storage: word in flight, prefetched word, last word sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            nxt_q     <= '0;
            nxt_len_q <= '0;
            last_q    <= '0;
        end else begin
            if (run && tick && begin_word) begin
                word_q <= first_word;
            end
            if (start) begin
                nxt_q     <= pick_word;
                nxt_len_q <= eff_len;
                last_q    <= pick_word;
            end
        end
    end

    // Underflow flag: set on an empty-register frame, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
        end else if (start && !hold_full) begin
            uf_q <= 1'b1;
        end else if (uf_clear) begin
            uf_q <= 1'b0;
        end
    end

    // R7: outputs move only on launch ticks while running.
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(dout_q) && $stable(fs_q)));

    // R2: disabled engine drives idle outputs.
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (!dout_q && !fs_q));

    // R9: frame sync never spans two consecutive slots.
    a_r9_fs_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && fs_q) |=> !fs_q);

    // R13: underflow stays set until a clear request.
    a_r13_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !uf_clear) |=> uf_q);

    // R11: underflow can only arise in free-running framing.
    a_r11_uf_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf_q) |-> $past(fcfg.free_run));

endmodule

// File: rtl/sync_serial_tx.sv
// Top of the serial transmitter: bit-clock source, holding register and
// framing engine. Frame-sync polarity is applied at the pin.
// Assumes configuration inputs change only while cfg_enable is low.
module sync_serial_tx
    import sstx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_int_clk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_lsb_first,
    input  logic              cfg_fall_edge,
    input  logic              cfg_fs_low,
    input  logic              cfg_fs_early,
    input  logic              cfg_fs_free,
    input  logic              ext_sclk,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    input  logic              uf_clear,
    output logic              ser_sclk,
    output logic              ser_dout,
    output logic              ser_fs,
    output logic              st_hold_empty,
    output logic              st_underflow
);
    logic              tick;
    logic              hold_full;
    logic [DATA_W-1:0] hold_word;
    logic              take;
    logic              fs_act;
    frame_cfg_t        fcfg;

    assign fcfg = '{lsb_first: cfg_lsb_first, early: cfg_fs_early,
                    free_run: cfg_fs_free};

    sstx_bitclk #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_bitclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (cfg_enable),
        .use_int     (cfg_int_clk),
        .launch_fall (cfg_fall_edge),
        .div         (cfg_div),
        .ext_clk     (ext_sclk),
        .sclk        (ser_sclk),
        .tick        (tick)
    );

    sstx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (s_valid),
        .wr_data  (s_data),
        .take     (take),
        .full     (hold_full),
        .word     (hold_word)
    );

    sstx_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cfg_enable),
        .tick      (tick),
        .len_cfg   (cfg_len),
        .fcfg      (fcfg),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .uf_clear  (uf_clear),
        .take      (take),
        .dout      (ser_dout),
        .fs_act    (fs_act),
        .underflow (st_underflow)
    );

    assign ser_fs        = fs_act ^ cfg_fs_low;
    assign s_ready       = !hold_full;
    assign st_hold_empty = !hold_full;

endmodule

// File: tb/sync_serial_tx_tb.sv
`timescale 1ns/1ps
module sync_serial_tx_tb;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 5;
    localparam int DIV_W  = 16;
    localparam int EXT_HALF = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_enable = 0, cfg_int_clk = 1, cfg_lsb_first = 0, cfg_fall_edge = 0;
    logic cfg_fs_low = 0, cfg_fs_early = 0, cfg_fs_free = 0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [LEN_W-1:0] cfg_len = 5'd7;
    logic ext_sclk = 0, s_valid = 0, uf_clear = 0;
    logic [DATA_W-1:0] s_data = '0;
    logic s_ready, ser_sclk, ser_dout, ser_fs, st_hold_empty, st_underflow;

    sync_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_int_clk(cfg_int_clk),
        .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .cfg_fall_edge(cfg_fall_edge), .cfg_fs_low(cfg_fs_low), .cfg_fs_early(cfg_fs_early),
        .cfg_fs_free(cfg_fs_free), .ext_sclk(ext_sclk), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .uf_clear(uf_clear), .ser_sclk(ser_sclk), .ser_dout(ser_dout),
        .ser_fs(ser_fs), .st_hold_empty(st_hold_empty), .st_underflow(st_underflow)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bits per word from the length field (R6).
    function automatic int word_bits(input int len);
        return ((len < 2) ? 2 : len) + 1;
    endfunction

    function automatic logic [31:0] bit_mask(input int bits);
        return 32'((64'd1 << bits) - 64'd1);
    endfunction

    // External bit clock generator.
    logic ext_run = 0;
    int ext_cnt = 0;
    always @(negedge clk) begin
        if (ext_run) begin
            ext_cnt++;
            if (ext_cnt == EXT_HALF) begin
                ext_sclk = ~ext_sclk;
                ext_cnt = 0;
            end
        end
    end

    // Receiver model and edge monitor, sampled at the falling clk edge.
    logic prev_sclk = 0, prev_dout = 0, prev_fs = 0, prev_en = 0;
    int half_cnt = 0, last_half = 0, viol = 0, fs_err = 0, nbits = 0;
    logic collecting = 0, pend = 0;
    logic [31:0] acc = '0;
    logic [31:0] rx_q[$];

    always @(negedge clk) begin
        logic sc_edge, launch, capture, fsa;
        sc_edge = (ser_sclk != prev_sclk);
        launch  = sc_edge && (ser_sclk == !cfg_fall_edge);
        capture = sc_edge && !launch;
        if (rst_n && cfg_enable && prev_en) begin
            half_cnt++;
            if (sc_edge) begin
                last_half = half_cnt;
                half_cnt = 0;
            end
            if ((ser_dout != prev_dout || ser_fs != prev_fs) && !launch) viol++;
            if (capture) begin
                fsa = ser_fs ^ cfg_fs_low;
                if (!cfg_fs_early) begin
                    if (fsa) begin
                        if (collecting) fs_err++;
                        collecting = 1; nbits = 0; acc = '0;
                    end
                end else begin
                    if (pend) begin
                        if (collecting) fs_err++;
                        collecting = 1; nbits = 0; acc = '0; pend = 0;
                    end
                    if (fsa) pend = 1;
                end
                if (collecting) begin
                    if (cfg_lsb_first) acc[nbits] = ser_dout;
                    else acc = {acc[30:0], ser_dout};
                    nbits++;
                    if (nbits == word_bits(int'(cfg_len))) begin
                        rx_q.push_back(acc);
                        collecting = 0;
                    end
                end
            end
        end else begin
            collecting = 0; pend = 0; half_cnt = 0;
        end
        prev_sclk = ser_sclk; prev_dout = ser_dout; prev_fs = ser_fs; prev_en = cfg_enable;
    end

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        s_valid = 1; s_data = w;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 0;
    endtask

    task automatic wait_rx(input int n);
        for (int t = 0; t < 30000 && rx_q.size() < n; t++) @(negedge clk);
    endtask

    // One configured run in data-driven framing: n words, then silence.
    task automatic run_case(input string req, input int div, input int len, input bit lsb,
                            input bit fall, input bit fslow, input bit early, input bit ext,
                            input int n);
        logic [31:0] sent[$];
        int bits;
        @(negedge clk);
        cfg_enable = 0;
        cfg_div = DIV_W'(div); cfg_len = LEN_W'(len); cfg_lsb_first = lsb;
        cfg_fall_edge = fall; cfg_fs_low = fslow; cfg_fs_early = early;
        cfg_fs_free = 0; cfg_int_clk = !ext; ext_run = ext;
        bits = word_bits(len);
        repeat (4) @(negedge clk);
        rx_q.delete(); viol = 0; fs_err = 0;
        cfg_enable = 1;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = $urandom;
            send(w);
            sent.push_back(w & bit_mask(bits));
        end
        wait_rx(n);
        chk(rx_q.size() == n, req, "words received", rx_q.size(), n);
        for (int i = 0; i < n && i < rx_q.size(); i++)
            chk((rx_q[i] & bit_mask(bits)) == sent[i], req, "word value (R5 R6 R8)",
                rx_q[i] & bit_mask(bits), sent[i]);
        chk(viol == 0, "R7", "changes off launch edge", viol, 0);
        chk(fs_err == 0, "R9", "frame sync placement errors", fs_err, 0);
        if (ext) chk(last_half == EXT_HALF, "R4", "external half period", last_half, EXT_HALF);
        else     chk(last_half == div + 1, "R3", "internal half period", last_half, div + 1);
        repeat (3 * bits * 2 * (ext ? EXT_HALF : div + 1)) @(negedge clk);
        chk(rx_q.size() == n, "R10", "no frame without data", rx_q.size(), n);
        chk(ser_dout == 1'b0, "R10", "idle data", ser_dout, 0);
        chk(st_underflow == 1'b0, "R10", "no underflow when data-driven", st_underflow, 0);
        cfg_enable = 0; ext_run = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w0, w1;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ser_dout == 0, "R1", "dout after reset", ser_dout, 0);
        chk(ser_fs == 0, "R1", "fs after reset", ser_fs, 0);
        chk(s_ready == 1, "R1", "ready after reset", s_ready, 1);
        chk(st_hold_empty == 1, "R1", "hold empty after reset", st_hold_empty, 1);
        chk(st_underflow == 0, "R1", "underflow after reset", st_underflow, 0);

        // Directed: short, long, early, active-low, falling edge, external clock
        run_case("R6", 1, 0, 0, 0, 0, 0, 0, 4);
        run_case("R6", 0, 31, 1, 1, 0, 1, 0, 3);
        run_case("R9", 2, 7, 0, 0, 1, 1, 0, 4);
        run_case("R8", 1, 11, 1, 1, 1, 0, 0, 4);
        run_case("R4", 0, 9, 0, 1, 0, 1, 1, 3);
        run_case("R5", 3, 15, 1, 0, 0, 0, 0, 3);
        // Constrained random configurations
        for (int k = 0; k < 6; k++) begin
            run_case("R5 R9", $urandom_range(0, 3), $urandom_range(2, 31),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0,
                     $urandom_range(2, 5));
        end

        // R2 and R12: word written while disabled stays held, outputs idle
        @(negedge clk);
        cfg_div = 16'd1; cfg_len = 5'd7; cfg_lsb_first = 0; cfg_fall_edge = 0;
        cfg_fs_low = 1; cfg_fs_early = 0; cfg_fs_free = 1; cfg_int_clk = 1;
        w0 = $urandom; w1 = $urandom;
        send(w0);
        chk(s_ready == 0, "R12", "ready low after accept", s_ready, 0);
        chk(st_hold_empty == 0, "R12", "hold empty low after accept", st_hold_empty, 0);
        repeat (40) @(negedge clk);
        chk(s_ready == 0, "R2", "word not consumed when off", s_ready, 0);
        chk(ser_dout == 0, "R2", "dout idle when off", ser_dout, 0);
        chk(ser_fs == 1, "R2", "fs inactive (active-low) when off", ser_fs, 1);

        // R11 free-running: w0, w1, then w1 resent with underflow
        rx_q.delete(); viol = 0; fs_err = 0;
        cfg_enable = 1;
        send(w1);
        wait_rx(4);
        chk(rx_q.size() >= 4, "R11", "free frames received", rx_q.size(), 4);
        if (rx_q.size() >= 4) begin
            chk(rx_q[0] == (w0 & 32'hFF), "R11", "first free word", rx_q[0], w0 & 32'hFF);
            chk(rx_q[1] == (w1 & 32'hFF), "R11", "second free word", rx_q[1], w1 & 32'hFF);
            chk(rx_q[2] == (w1 & 32'hFF), "R11", "resent word", rx_q[2], w1 & 32'hFF);
            chk(rx_q[3] == (w1 & 32'hFF), "R11", "resent word again", rx_q[3], w1 & 32'hFF);
        end
        chk(fs_err == 0, "R9", "free frame sync placement", fs_err, 0);
        chk(st_underflow == 1, "R13", "underflow set", st_underflow, 1);
        @(negedge clk);
        cfg_enable = 0;
        repeat (5) @(negedge clk);
        chk(st_underflow == 1, "R13", "underflow sticky", st_underflow, 1);
        uf_clear = 1;
        @(negedge clk);
        uf_clear = 0;
        chk(st_underflow == 0, "R13", "underflow cleared", st_underflow, 0);
        chk(s_ready == 1, "R12", "ready after drain", s_ready, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule